// File: doc/BRIEF.md
# Paired Output Compare Controller

This block holds two output compare channels, channel 0 and channel 1, that watch one shared free-running timer count. Each channel has its own compare register. The timer is presented as a count value together with a strobe that marks the cycles on which the timer advances. When a channel is enabled and its compare register equals the timer count on a strobe cycle, the channel sets a match flag. While both the flag and that channel's interrupt enable are set, the channel requests service. The block drives one interrupt line, which is the OR of the two channel requests.

Both channels share one 8-bit control/status byte. The match flags in this byte follow special access rules:
- Software clears a flag by writing 0 to it.
- Writing 1 to a flag leaves it unchanged.
- A read marked as read-modify-write returns 1 in both flag positions.

With these rules, a read-modify-write that sets or clears some other bit cannot drop a flag that is still pending.

Top module: `paired_ocu`

## Requirements
- R1: After reset, both compare registers read 0x0000, the control/status byte reads 0x00 and irq is 0.
- R2: Addressing uses addr 0 for the control/status byte (placed in the low 8 bits, upper bits read 0), addr 1 for the channel 0 compare register and addr 2 for the channel 1 compare register. Addr 3 reads 0. The control/status bits are: 7 = channel 1 flag, 6 = channel 0 flag, 5 = channel 1 interrupt enable, 4 = channel 0 interrupt enable, 1 = channel 1 compare enable, 0 = channel 0 compare enable. Both enable pairs are read/write.
- R3: Suppose that on some cycle timer_tick is 1, the channel's compare enable is 1, and its compare register equals timer_val. Then the channel's flag reads 1 after the next rising clock edge.
- R4: A channel never sets its flag on a cycle where timer_tick is 0 or where its compare enable is 0.
- R5: Writing 0 to a flag bit clears it at the next edge. Writing 1 to a flag bit leaves it unchanged.
- R6: If a match and a clearing write to the same flag fall on the same cycle, the flag ends up set.
- R7: While rmw_read is 1, a read of addr 0 returns 1 in bits 7 and 6. All other bits of that read keep their true values. When rmw_read is 0, the read returns the true flag state.
- R8: Bits 3 and 2 of the control/status byte always read 0, and writes to them have no effect.
- R9: irq is 1 exactly when some channel has both its flag and its interrupt enable set. irq follows the register state without any further delay.
- R10: A compare register can be rewritten at any time, including while its channel is enabled. From the next cycle on, comparisons use the new value and no longer use the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_val | input | TW | Free-running timer count |
| timer_tick | input | 1 | Timer count-enable strobe; compares happen only when this is high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 control/status, 1 channel 0 compare, 2 channel 1 compare) |
| wr_data | input | TW | Write data; control/status writes use bits 7:0 |
| rd_addr | input | 2 | Read address, same map as writes |
| rmw_read | input | 1 | Marks the read as part of a read-modify-write |
| rd_data | output | TW | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes and flag sets both land on the first rising edge after the cycle that carries the write or the matching strobe. rd_data and irq are combinational from the registered state. The bench drives every stimulus at a falling edge and holds it for one full cycle. It then samples at the following falling edge, exactly one register stage later. Reads settle rd_addr and rmw_read, wait one time unit, and then compare, so the result never depends on which process runs first at an edge. Same-cycle collisions, such as a match together with a clearing write, are produced by raising both inputs at the same falling edge.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int CSR_W      = 8;
    localparam int FLAG_BASE  = 6;
    localparam int IE_BASE    = 4;
    localparam int CEN_BASE   = 0;
    localparam logic [1:0] ADDR_CSR  = 2'd0;
    localparam logic [1:0] ADDR_CMP0 = 2'd1;
    localparam logic [1:0] ADDR_CMP1 = 2'd2;
endpackage

// File: rtl/ocu_channel.sv
module ocu_channel #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          timer_tick,
    input  logic          cmp_we,
    input  logic [TW-1:0] cmp_wdata,
    input  logic          ctl_we,
    input  logic          ctl_flag_bit,
    input  logic          ctl_ie_bit,
    input  logic          ctl_cen_bit,
    output logic [TW-1:0] cmp_val,
    output logic          cen,
    output logic          ie,
    output logic          flag,
    output logic          req
);
    typedef struct packed {
        logic [TW-1:0] cmp;
        logic          cen;
        logic          ie;
        logic          flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = timer_tick && st_q.cen && (st_q.cmp == timer_val);
        if (cmp_we) st_d.cmp = cmp_wdata;
        if (ctl_we) begin
            st_d.cen = ctl_cen_bit;
            st_d.ie  = ctl_ie_bit;
        end
        st_d.flag = hit || (st_q.flag && !(ctl_we && !ctl_flag_bit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_val = st_q.cmp;
    assign cen     = st_q.cen;
    assign ie      = st_q.ie;
    assign flag    = st_q.flag;
    assign req     = st_q.flag && st_q.ie;

    // R3 R6
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_tick && cen && cmp_val == timer_val) |=> flag);

    // R4
    no_detect_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && (!timer_tick || !cen)) |=> !flag);

    // R5
    write_one_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_flag_bit && flag) |=> flag);

    // R5
    write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_flag_bit && flag && !hit) |=> !flag);
endmodule

// File: rtl/ocu_readmux.sv
module ocu_readmux #(
    parameter int TW = 16
) (
    input  logic [1:0]    rd_addr,
    input  logic          rmw_read,
    input  logic [1:0]    flag,
    input  logic [1:0]    ie,
    input  logic [1:0]    cen,
    input  logic [TW-1:0] cmp0,
    input  logic [TW-1:0] cmp1,
    output logic [TW-1:0] rd_data
);
    import ocu_pkg::*;

    logic [CSR_W-1:0] csr_byte;

    always_comb begin
        csr_byte = '0;
        for (int i = 0; i < 2; i++) begin
            csr_byte[FLAG_BASE+i] = flag[i] || rmw_read;
            csr_byte[IE_BASE+i]   = ie[i];
            csr_byte[CEN_BASE+i]  = cen[i];
        end
        case (rd_addr)
            ADDR_CSR:  rd_data = {{(TW-CSR_W){1'b0}}, csr_byte};
            ADDR_CMP0: rd_data = cmp0;
            ADDR_CMP1: rd_data = cmp1;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/paired_ocu.sv
module paired_ocu #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          timer_tick,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    input  logic          rmw_read,
    output logic [TW-1:0] rd_data,
    output logic          irq
);
    import ocu_pkg::*;

    logic [1:0]    flag_w, ie_w, cen_w, req_w;
    logic [TW-1:0] cmp_w [2];
    logic          csr_we;

    assign csr_we = wr_en && (wr_addr == ADDR_CSR);

    for (genvar g = 0; g < 2; g++) begin : g_chan
        localparam logic [1:0] CMP_ADDR = ADDR_CMP0 + 2'(g);
        ocu_channel #(.TW(TW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .timer_val    (timer_val),
            .timer_tick   (timer_tick),
            .cmp_we       (wr_en && (wr_addr == CMP_ADDR)),
            .cmp_wdata    (wr_data),
            .ctl_we       (csr_we),
            .ctl_flag_bit (wr_data[FLAG_BASE+g]),
            .ctl_ie_bit   (wr_data[IE_BASE+g]),
            .ctl_cen_bit  (wr_data[CEN_BASE+g]),
            .cmp_val      (cmp_w[g]),
            .cen          (cen_w[g]),
            .ie           (ie_w[g]),
            .flag         (flag_w[g]),
            .req          (req_w[g])
        );
    end

    ocu_readmux #(.TW(TW)) u_rdmux (
        .rd_addr  (rd_addr),
        .rmw_read (rmw_read),
        .flag     (flag_w),
        .ie       (ie_w),
        .cen      (cen_w),
        .cmp0     (cmp_w[0]),
        .cmp1     (cmp_w[1]),
        .rd_data  (rd_data)
    );

    assign irq = |req_w;

    // R7
    rmw_flags_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_CSR && rmw_read) |-> (rd_data[7:6] == 2'b11));

    // R8
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_CSR) |-> (rd_data[3:2] == 2'b00));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_w != 2'b00));
endmodule

// File: tb/paired_ocu_test.sv
module paired_ocu_test;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] timer_val = '0;
    logic          timer_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic          rmw_read = 1'b0;
    logic [TW-1:0] rd_data;
    logic          irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    paired_ocu #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .timer_tick(timer_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rmw_read(rmw_read), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic rmw,
                            input logic [TW-1:0] exp);
        rd_addr  = a;
        rmw_read = rmw;
        #1;
        check(req, rd_data, exp);
        rmw_read = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        check(req, {{(TW-1){1'b0}}, irq}, {{(TW-1){1'b0}}, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [TW-1:0] v, input logic strobe);
        @(negedge clk);
        timer_val = v; timer_tick = strobe;
        @(negedge clk);
        timer_tick = 1'b0;
    endtask

    task automatic t_reset;
        read_chk("R1 csr", 2'd0, 1'b0, 16'h0000);
        read_chk("R1 cmp0", 2'd1, 1'b0, 16'h0000);
        read_chk("R1 cmp1", 2'd2, 1'b0, 16'h0000);
        read_chk("R2 addr3", 2'd3, 1'b0, 16'h0000);
        irq_chk("R1 irq", 1'b0);
    endtask

    task automatic t_csr_rw;
        wr(2'd0, 16'h003F);
        read_chk("R2 R8 csr write", 2'd0, 1'b0, 16'h0033);
        wr(2'd0, 16'h0000);
        read_chk("R2 csr clear", 2'd0, 1'b0, 16'h0000);
    endtask

    task automatic t_nomatch;
        wr(2'd1, 16'h0010);
        read_chk("R2 cmp0 readback", 2'd1, 1'b0, 16'h0010);
        tick(16'h0010, 1'b1);
        read_chk("R4 disabled", 2'd0, 1'b0, 16'h0000);
        wr(2'd0, 16'h0001);
        tick(16'h0010, 1'b0);
        read_chk("R4 no strobe", 2'd0, 1'b0, 16'h0001);
        tick(16'h0011, 1'b1);
        read_chk("R3 mismatch", 2'd0, 1'b0, 16'h0001);
    endtask

    task automatic t_match;
        tick(16'h0010, 1'b1);
        read_chk("R3 match ch0", 2'd0, 1'b0, 16'h0041);
        irq_chk("R9 ie off", 1'b0);
        wr(2'd0, 16'h0051);
        read_chk("R5 write one keeps", 2'd0, 1'b0, 16'h0051);
        irq_chk("R9 ie on", 1'b1);
    endtask

    task automatic t_rmw;
        read_chk("R7 rmw read", 2'd0, 1'b1, 16'h00D1);
        read_chk("R7 plain read", 2'd0, 1'b0, 16'h0051);
    endtask

    task automatic t_clear;
        wr(2'd0, 16'h0011);
        read_chk("R5 write zero clears", 2'd0, 1'b0, 16'h0011);
        irq_chk("R9 cleared", 1'b0);
    endtask

    task automatic t_odd;
        wr(2'd2, 16'hBEEF);
        read_chk("R2 cmp1 readback", 2'd2, 1'b0, 16'hBEEF);
        wr(2'd0, 16'h0023);
        tick(16'hBEEF, 1'b1);
        read_chk("R3 match ch1", 2'd0, 1'b0, 16'h00A3);
        irq_chk("R9 ch1", 1'b1);
    endtask

    task automatic t_setwins;
        wr(2'd1, 16'h0020);
        @(negedge clk);
        timer_val = 16'h0020; timer_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0023;
        @(negedge clk);
        timer_tick = 1'b0; wr_en = 1'b0;
        read_chk("R6 set beats clear", 2'd0, 1'b0, 16'h0063);
    endtask

    task automatic t_rewrite;
        wr(2'd0, 16'h0003);
        read_chk("R5 clear both", 2'd0, 1'b0, 16'h0003);
        wr(2'd1, 16'h0100);
        tick(16'h0020, 1'b1);
        read_chk("R10 old value ignored", 2'd0, 1'b0, 16'h0003);
        tick(16'h0100, 1'b1);
        read_chk("R10 new value used", 2'd0, 1'b0, 16'h0043);
        read_chk("R10 cmp0 readback", 2'd1, 1'b0, 16'h0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_csr_rw;
        t_nomatch;
        t_match;
        t_rmw;
        t_clear;
        t_odd;
        t_setwins;
        t_rewrite;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule